// File: doc/BRIEF.md
# Auxiliary Packet Slot Scheduler

This block decides which auxiliary packet a display transmitter sends next while video is blanked. Software programs two slot words, each carrying four 4-bit packet-type fields. Together they form an ordered list of up to eight entries. On every frame-start pulse the block takes a fresh copy of that list and begins again at the first slot. It offers each packet type to the packet encoder with a valid/accept handshake and moves on only when the encoder takes it.

The list ends at the first end marker, or after the last slot if no marker appears. Codes the transmitter has no packet for are passed over without a handshake. Software may rewrite the slot words at any time. A rewrite never changes the sequence that is running, because the working copy is refreshed only by the next frame-start pulse.

Top module: `pkt_slot_sched`

## Requirements
- R1: After reset, pktValid is low and the stored list is empty (every slot holds the end code 15). A frame-start pulse with no prior write therefore issues no packet.
- R2: In slot word w, slot s is held in bits [4s+3:4s]. Bits 16 to 31 are ignored. Slots are visited in the order word 0 slots 0..3, then word 1 slots 0..3.
- R3: While pktValid is high and pktAccept is low, pktValid stays high and pktType keeps its value on the next cycle, unless frameStart intervenes.
- R4: Each cycle with pktValid and pktAccept both high hands over exactly one packet, and the next slot is examined from the following cycle.
- R5: Type code 15 ends the list. No later slot is visited, and pktValid stays low until the next frame-start pulse.
- R6: If the list contains no end code, the sequence ends after the eighth slot is handled.
- R7: The issued codes are 0, 1, 2, 3 and 5. Codes 4 and 6 to 14 are skipped without raising pktValid, and each skipped slot takes one clock cycle.
- R8: A slot-word write (cfgWrEn high, cfgWrSel picks the word) is used only from the frame-start pulse after the write cycle. A write in the same cycle as frameStart is not used by the frame that pulse starts.
- R9: frameStart restarts the sequence at slot 0, even partway through a list. In the cycle frameStart is high, pktValid is low, so accept has no effect.
- R10: The program general control (1), AVI (2), audio info (3), end (15) in word 0, with word 1 at zero, yields exactly the types 1, 2, 3 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Slot-word write strobe |
| cfgWrSel | input | 1 | Selects which slot word is written |
| cfgWrData | input | 32 | Slot-word write data |
| frameStart | input | 1 | One-cycle pulse starting a new frame's list |
| pktAccept | input | 1 | Encoder takes the offered packet |
| pktValid | output | 1 | A packet type is offered |
| pktType | output | 4 | Offered packet type code |

## Verification
A frame-start pulse can arrive in the same cycle that the encoder accepts a packet. It can also coincide with a slot-word write. The bench lines up both collisions on purpose. In the first, it runs a list partway, then raises frameStart and pktAccept together, and it requires pktValid to drop in that cycle and the whole list to replay from slot 0. In the second, it writes a new word on the pulse cycle, and it requires that frame to follow the old list and the next frame to follow the new one.

// File: rtl/pkt_sched_pkg.sv
package pkt_sched_pkg;
  localparam int CODE_W   = 4;
  localparam logic [CODE_W-1:0] END_CODE = 4'hF;

  // strobes from sequencing control to the slot datapath
  typedef struct packed {
    logic restart;
    logic advance;
  } seqStrobeT;

  function automatic logic isSendable(input logic [CODE_W-1:0] code);
    case (code)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd5: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pkt_slot_dp.sv
module pkt_slot_dp
  import pkt_sched_pkg::*;
#(
  parameter int SLOTS_PER_WORD = 4,
  parameter int NUM_WORDS      = 2,
  localparam int SLOT_BITS = SLOTS_PER_WORD * CODE_W,
  localparam int TOTAL     = SLOTS_PER_WORD * NUM_WORDS,
  localparam int IDX_W     = (TOTAL > 1) ? $clog2(TOTAL) : 1,
  localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [SEL_W-1:0]     cfgWrSel,
  input  logic [SLOT_BITS-1:0] cfgWrData,
  input  logic                 frameStart,
  input  seqStrobeT            strobes,
  output logic [CODE_W-1:0]    curCode,
  output logic                 atLastSlot
);
  logic [SLOT_BITS-1:0]      stagedWord [NUM_WORDS];
  logic [TOTAL*CODE_W-1:0]   stagedFlat;
  logic [TOTAL*CODE_W-1:0]   activeList;
  logic [IDX_W-1:0]          cursor;

  // shadow words written by software
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN)
        stagedWord[w] <= '1;
      else if (cfgWrEn && (cfgWrSel == SEL_W'(w)))
        stagedWord[w] <= cfgWrData;
    end
    assign stagedFlat[w*SLOT_BITS +: SLOT_BITS] = stagedWord[w];
  end

  // working copy, refreshed only on restart
  always_ff @(posedge clk) begin
    if (!rstN)
      activeList <= '1;
    else if (strobes.restart)
      activeList <= stagedFlat;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      cursor <= '0;
    else if (strobes.restart)
      cursor <= '0;
    else if (strobes.advance)
      cursor <= cursor + IDX_W'(1);
  end

  assign curCode    = activeList[int'(cursor)*CODE_W +: CODE_W];
  assign atLastSlot = (cursor == IDX_W'(TOTAL - 1));

  // R8: the working list only moves on a frame-start pulse
  assert_list_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(activeList));

  // R4: one accepted step moves the cursor by exactly one slot
  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && !strobes.restart) |=> cursor == $past(cursor) + IDX_W'(1));
endmodule

// File: rtl/pkt_seq_ctl.sv
module pkt_seq_ctl
  import pkt_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              pktAccept,
  input  logic [CODE_W-1:0] curCode,
  input  logic              atLastSlot,
  output seqStrobeT         strobes,
  output logic              pktValid,
  output logic [CODE_W-1:0] pktType
);
  logic running;
  logic codeSendable;
  logic codeEnd;
  logic stepNow;
  logic stopNow;

  always_comb begin
    codeSendable    = isSendable(curCode);
    codeEnd         = (curCode == END_CODE);
    stepNow         = running && !frameStart && !codeEnd && (!codeSendable || pktAccept);
    stopNow         = running && !frameStart && (codeEnd || (atLastSlot && stepNow));
    strobes.restart = frameStart;
    strobes.advance = stepNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      running <= 1'b0;
    else if (frameStart)
      running <= 1'b1;
    else if (stopNow)
      running <= 1'b0;
  end

  assign pktValid = running && codeSendable && !frameStart;
  assign pktType  = curCode;

  // R3: an offer is held until taken
  assert_offer_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktAccept) |=> (frameStart || (pktValid && $stable(pktType))));

  // R7: only issuable codes are ever offered
  assert_legal_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (pktType inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5}));

  // R5: an end code silences the output until the next pulse
  assert_end_stops_R5: assert property (@(posedge clk) disable iff (!rstN)
    (running && codeEnd && !frameStart) |=> !pktValid);

  // R9: no handshake in a restart cycle
  assert_restart_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !pktValid);
endmodule

// File: rtl/pkt_slot_sched.sv
module pkt_slot_sched
  import pkt_sched_pkg::*;
#(
  parameter int REG_W          = 32,
  parameter int SLOTS_PER_WORD = 4,
  parameter int NUM_WORDS      = 2,
  localparam int SLOT_BITS = SLOTS_PER_WORD * CODE_W,
  localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [SEL_W-1:0]  cfgWrSel,
  input  logic [REG_W-1:0]  cfgWrData,
  input  logic              frameStart,
  input  logic              pktAccept,
  output logic              pktValid,
  output logic [CODE_W-1:0] pktType
);
  seqStrobeT         strobes;
  logic [CODE_W-1:0] curCode;
  logic              atLastSlot;
  logic              unusedHighBits;

  // slot fields fill only the low part of each word
  if (REG_W > SLOT_BITS) begin : g_spare
    assign unusedHighBits = ^cfgWrData[REG_W-1:SLOT_BITS];
  end else begin : g_nospare
    assign unusedHighBits = 1'b0;
  end

  pkt_slot_dp #(
    .SLOTS_PER_WORD(SLOTS_PER_WORD),
    .NUM_WORDS     (NUM_WORDS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrSel  (cfgWrSel),
    .cfgWrData (cfgWrData[SLOT_BITS-1:0]),
    .frameStart(frameStart),
    .strobes   (strobes),
    .curCode   (curCode),
    .atLastSlot(atLastSlot)
  );

  pkt_seq_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .pktAccept (pktAccept),
    .curCode   (curCode),
    .atLastSlot(atLastSlot),
    .strobes   (strobes),
    .pktValid  (pktValid),
    .pktType   (pktType)
  );
endmodule

// File: tb/pkt_slot_sched_bench.sv
module pkt_slot_sched_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [0:0]  cfgWrSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        frameStart = 1'b0;
  logic        pktAccept = 1'b0;
  logic        pktValid;
  logic [3:0]  pktType;

  int checks = 0;
  int fails = 0;
  int expTypes[8];
  int expCount;
  int gotTypes[64];
  int gotCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_slot_sched u_pkt_slot_sched (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .frameStart(frameStart), .pktAccept(pktAccept),
    .pktValid(pktValid), .pktType(pktType)
  );

  function automatic void check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endfunction

  function automatic bit legalCode(int code);
    return (code <= 3) || (code == 5);
  endfunction

  // expected packet list from the two slot words
  function automatic void buildExpected(logic [31:0] a, logic [31:0] b);
    expCount = 0;
    for (int w = 0; w < 2; w++) begin
      for (int s = 0; s < 4; s++) begin
        int code = int'(((w == 0) ? a : b) >> (4*s)) & 15;
        if (code == 15) return;
        if (legalCode(code)) begin
          expTypes[expCount] = code;
          expCount++;
        end
      end
    end
  endfunction

  task automatic writeWord(int sel, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = 1'(sel); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameStart = 1'b1; pktAccept = 1'b0;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // run a window, random accept for randCycles then always accept
  task automatic runWindow(int cycles, int randCycles);
    bit prevV = 0, prevA = 0;
    int prevT = 0;
    gotCount = 0;
    for (int c = 0; c < cycles; c++) begin
      bit v, acc;
      int t;
      #1;
      v = pktValid; t = int'(pktType);
      if (prevV && !prevA)
        check(v && (t == prevT), "R3", "held offer", t, prevT);
      acc = (c >= randCycles) ? 1'b1 : 1'($urandom % 2);
      pktAccept = acc;
      if (v && acc) begin
        gotTypes[gotCount] = t;
        gotCount++;
      end
      prevV = v; prevA = acc; prevT = t;
      @(negedge clk);
    end
    pktAccept = 1'b0;
    #1;
    check(!pktValid, "R5", "idle after list", int'(pktValid), 0);
  endtask

  task automatic compareList(string req);
    check(gotCount == expCount, req, "packet count", gotCount, expCount);
    for (int i = 0; i < gotCount && i < expCount; i++)
      check(gotTypes[i] == expTypes[i], req, "packet type", gotTypes[i], expTypes[i]);
  endtask

  task automatic doFrame(logic [31:0] a, logic [31:0] b, string req);
    writeWord(0, a);
    writeWord(1, b);
    pulseFrame();
    buildExpected(a, b);
    runWindow(40, 20);
    compareList(req);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(!pktValid, "R1", "valid after reset", int'(pktValid), 0);

    // R1: empty list after reset
    pulseFrame();
    buildExpected(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    runWindow(20, 0);
    compareList("R1");

    // R10: typical program
    doFrame(32'h0000_F321, 32'h0000_0000, "R10");

    // R6 and R2: no end code, upper bits ignored, word order
    doFrame(32'hABCD_0123, 32'h1234_5555, "R6");
    doFrame(32'hFFFF_1203, 32'h0000_F250, "R2");

    // R7: reserved slot costs one quiet cycle
    writeWord(0, 32'h0000_0F14);
    pulseFrame();
    #1;
    check(!pktValid, "R7", "reserved slot offered", int'(pktValid), 0);
    @(negedge clk); #1;
    check(pktValid && pktType == 4'd1, "R7", "type after skip", int'(pktType), 1);
    pktAccept = 1'b1;
    @(negedge clk);
    pktAccept = 1'b0; #1;
    check(!pktValid, "R5", "end after one packet", int'(pktValid), 0);
    doFrame(32'h0000_E9C6, 32'h0000_F7A2, "R7");

    // R9 and R4: frame pulse collides with an accept partway through
    writeWord(0, 32'h0000_5321);
    writeWord(1, 32'h0000_3210);
    pulseFrame();
    for (int k = 1; k <= 2; k++) begin
      #1;
      check(pktValid && int'(pktType) == k, "R4", "stepped type", int'(pktType), k);
      pktAccept = 1'b1;
      @(negedge clk);
    end
    #1;
    check(pktValid && pktType == 4'd3, "R4", "third type", int'(pktType), 3);
    frameStart = 1'b1; pktAccept = 1'b1;
    #1;
    check(!pktValid, "R9", "valid in restart cycle", int'(pktValid), 0);
    @(negedge clk);
    frameStart = 1'b0; pktAccept = 1'b0;
    buildExpected(32'h0000_5321, 32'h0000_3210);
    runWindow(40, 10);
    compareList("R9");

    // R8: write on the pulse cycle is held back one frame
    @(negedge clk);
    frameStart = 1'b1; cfgWrEn = 1'b1; cfgWrSel = 1'b0; cfgWrData = 32'h0000_FFF2;
    @(negedge clk);
    frameStart = 1'b0; cfgWrEn = 1'b0;
    runWindow(40, 10);
    compareList("R8");
    pulseFrame();
    buildExpected(32'h0000_FFF2, 32'h0000_3210);
    runWindow(30, 5);
    compareList("R8");

    // R8: a write with no pulse leaves the idle output alone
    writeWord(1, 32'h0000_1111);
    #1;
    check(!pktValid, "R8", "write without pulse", int'(pktValid), 0);

    // random programs
    for (int f = 0; f < 25; f++)
      doFrame($urandom, $urandom, "R4");

    finishRun();
  end
endmodule